// File: doc/BRIEF.md
# Single-Clock Word FIFO With Quarter-Fill Code

This block is a first-in, first-out buffer for 32-bit words on a single clock. It sits between a producer that delivers words in bursts, such as the read path of a DRAM controller, and a consumer that drains them at its own pace. The producer raises `push` with a word on `wdata`. The consumer raises `pop`, and the oldest stored word appears on `rdata` one clock later. It stays there until the next accepted pop.

Besides `full` and `empty`, the block reports a coarse 2-bit fill code, `fill_qtr`. This code tells which quarter of the capacity is in use, so a consumer can pace itself without an exact word count. A synchronous clear input, `clr`, discards every stored word. This input is also the block's only means of initialization.

Top module: `qfifo_sync`

## Requirements
- R1: On a clock edge with `clr` high, the buffer is emptied. After that edge, `empty`=1, `full`=0, `fill_qtr`=2'b00 and `rdata`=0.
- R2: On an edge with `push` high and `full` low, the word on `wdata` is stored behind all words already held.
- R3: On an edge with `pop` high and `empty` low, the oldest stored word is removed and shown on `rdata` after that edge. Words leave in the order they were stored. In every other cycle `rdata` keeps its value.
- R4: `empty` is high exactly when no words are held, and `empty` and `full` are never high together.
- R5: `full` is high exactly when 32 words (the default depth) are held.
- R6: A push while `full` is high is ignored: no word is stored and the held words are unchanged.
- R7: A pop while `empty` is high is ignored: `rdata` keeps its value and the buffer stays empty. This holds even if a push in the same cycle makes the buffer non-empty.
- R8: `fill_qtr` encodes the number of held words n (depth 32) as 2'b00 for n=0..7, 2'b01 for n=8..15, 2'b10 for n=16..23 and 2'b11 for n=24..32.
- R9: When a push and a pop are both accepted on the same edge, the number of held words is unchanged. `rdata` shows the oldest word and the new word joins the tail.
- R10: `clr` takes priority over `push` and `pop` in the same cycle. Neither of them has any effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| clr | input | 1 | Synchronous clear, empties the buffer |
| push | input | 1 | Store `wdata` on this edge |
| wdata | input | 32 | Word to store |
| pop | input | 1 | Remove the oldest word on this edge |
| rdata | output | 32 | Word removed by the last accepted pop |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entries in use |
| fill_qtr | output | 2 | Quarter-of-capacity fill code |

## Verification
All results are registered, so every effect of a stimulus is due in the cycle that follows the edge which samples it. `rdata`, `full`, `empty` and `fill_qtr` reflect a push, a pop or a clear one edge after it. The bench drives its inputs at the falling edge and samples all outputs shortly after the next rising edge. It holds an independent model of the held words, and after each such step it compares all four outputs with that model. The quarter-code boundaries are checked at every fill level on the way from empty to full.

// File: rtl/qfifo_pkg.sv
package qfifo_pkg;

  // Quarter-of-capacity code for an occupancy value; saturates at 3 when full.
  function automatic logic [1:0] quartile_of(int unsigned occ, int unsigned depth);
    int unsigned q;
    q = (occ * 4) / depth;
    if (q > 3) q = 3;
    return 2'(q);
  endfunction

  // Next occupancy given the accepted operations of one cycle.
  function automatic int unsigned next_occ(int unsigned occ, logic wr_ok, logic rd_ok);
    int unsigned n;
    n = occ;
    if (wr_ok && !rd_ok) n = occ + 1;
    if (rd_ok && !wr_ok) n = occ - 1;
    return n;
  endfunction

endpackage

// File: rtl/qfifo_ptr_ctrl.sv
module qfifo_ptr_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] occ_q;

  assign empty   = (occ_q == '0);
  assign full    = (occ_q == CW'(DEPTH));
  assign wr_fire = push && !full && !clr;
  assign rd_fire = pop && !empty && !clr;
  assign wr_addr = wr_ptr_q;
  assign rd_addr = rd_ptr_q;
  assign occ     = occ_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (wr_fire) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rd_fire) rd_ptr_q <= rd_ptr_q + AW'(1);
      occ_q <= CW'(qfifo_pkg::next_occ(int'(occ_q), wr_fire, rd_fire));
    end
  end
endmodule

// File: rtl/qfifo_store.sv
module qfifo_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_fire,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)          rdata <= '0;
    else if (rd_fire) rdata <= mem[rd_addr];
  end
endmodule

// File: rtl/qfifo_quartile.sv
module qfifo_quartile #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] occ,
  output logic [1:0]    fill_qtr
);
  generate
    if ((DEPTH & (DEPTH - 1)) == 0 && DEPTH >= 4) begin : g_pow2
      // Top two bits of the in-range count; the full count saturates to 3.
      assign fill_qtr = occ[CW-1] ? 2'b11 : occ[CW-2 -: 2];
    end else begin : g_generic
      assign fill_qtr = qfifo_pkg::quartile_of(int'(occ), DEPTH);
    end
  endgenerate
endmodule

// File: rtl/qfifo_sync.sv
module qfifo_sync #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic [1:0]    fill_qtr
);
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] occ;

  qfifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .clr(clr), .push(push), .pop(pop),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_addr(wr_addr), .rd_addr(rd_addr),
    .occ(occ), .full(full), .empty(empty)
  );

  qfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .clr(clr),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wdata(wdata),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rdata(rdata)
  );

  qfifo_quartile #(.DEPTH(DEPTH)) u_qtr (
    .occ(occ), .fill_qtr(fill_qtr)
  );
endmodule

// File: rtl/qfifo_sync_chk.sv
module qfifo_sync_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          clr,
  input logic          push,
  input logic          pop,
  input logic          full,
  input logic          empty,
  input logic [1:0]    fill_qtr,
  input logic [DW-1:0] rdata,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [CW-1:0] occ
);
  logic primed = 1'b0;
  always_ff @(posedge clk) if (clr) primed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk)
    clr |=> (empty && !full && fill_qtr == 2'b00 && rdata == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (clr || !primed)
    wr_fire |-> (push && !full));

  p_hold_r3: assert property (@(posedge clk) disable iff (clr || !primed)
    !rd_fire |=> $stable(rdata));

  p_excl_r4: assert property (@(posedge clk) disable iff (clr || !primed)
    !(full && empty));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (clr || !primed)
    (full && push && !pop) |=> (full && $stable(occ)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (clr || !primed)
    (empty && pop && !push) |=> (empty && $stable(rdata)));

  p_qtr_ends_r8: assert property (@(posedge clk) disable iff (clr || !primed)
    (full |-> fill_qtr == 2'b11) and (empty |-> fill_qtr == 2'b00));

  p_grow_r2: assert property (@(posedge clk) disable iff (clr || !primed)
    (wr_fire && !rd_fire) |=> occ == $past(occ) + 1'b1);

  p_balance_r9: assert property (@(posedge clk) disable iff (clr || !primed)
    (wr_fire && rd_fire) |=> $stable(occ));
endmodule

bind qfifo_sync qfifo_sync_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .clr(clr), .push(push), .pop(pop),
  .full(full), .empty(empty), .fill_qtr(fill_qtr), .rdata(rdata),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .occ(occ)
);

// File: tb/qfifo_sync_tb.sv
module qfifo_sync_tb;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        full, empty;
  logic [1:0]  fill_qtr;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  // independent model
  logic [31:0] mq [32];
  int head = 0, tail = 0, cnt = 0;
  logic [31:0] m_rdata = '0;

  always #5 clk = ~clk;

  qfifo_sync u_dut (
    .clk(clk), .clr(clr), .push(push), .wdata(wdata), .pop(pop),
    .rdata(rdata), .full(full), .empty(empty), .fill_qtr(fill_qtr)
  );

  // {push, pop, wdata, exp_rdata, exp_empty, exp_qtr}
  localparam logic [68:0] VEC [9] = '{
    {1'b1, 1'b0, 32'hCAFE_0001, 32'h0000_0000, 1'b0, 2'b00},
    {1'b1, 1'b0, 32'hCAFE_0002, 32'h0000_0000, 1'b0, 2'b00},
    {1'b0, 1'b1, 32'h0000_0000, 32'hCAFE_0001, 1'b0, 2'b00},
    {1'b1, 1'b1, 32'hCAFE_0003, 32'hCAFE_0002, 1'b0, 2'b00},
    {1'b0, 1'b1, 32'h0000_0000, 32'hCAFE_0003, 1'b1, 2'b00},
    {1'b0, 1'b1, 32'h0000_0000, 32'hCAFE_0003, 1'b1, 2'b00},
    {1'b1, 1'b1, 32'hCAFE_0004, 32'hCAFE_0003, 1'b0, 2'b00},
    {1'b0, 1'b0, 32'h0000_0000, 32'hCAFE_0003, 1'b0, 2'b00},
    {1'b0, 1'b1, 32'h0000_0000, 32'hCAFE_0004, 1'b1, 2'b00}
  };

  function automatic logic [1:0] band(int n);
    if (n >= 24) return 2'b11;
    if (n >= 16) return 2'b10;
    if (n >= 8)  return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_check(string tag);
    chk(tag, "rdata", rdata, m_rdata);
    chk(tag, "empty", 32'(empty), 32'(cnt == 0));
    chk(tag, "full", 32'(full), 32'(cnt == 32));
    chk(tag, "fill_qtr", 32'(fill_qtr), 32'(band(cnt)));
  endtask

  task automatic step(logic p, logic q, logic [31:0] d, string tag);
    bit rd_ok, wr_ok;
    @(negedge clk);
    push = p; pop = q; wdata = d;
    rd_ok = q && (cnt > 0);
    wr_ok = p && (cnt < 32);
    @(posedge clk);
    #1;
    if (rd_ok) begin m_rdata = mq[head]; head = (head + 1) % 32; cnt--; end
    if (wr_ok) begin mq[tail] = d; tail = (tail + 1) % 32; cnt++; end
    push = 1'b0; pop = 1'b0;
    model_check(tag);
  endtask

  task automatic do_clear(logic p, logic q, string tag);
    @(negedge clk);
    clr = 1'b1; push = p; pop = q; wdata = 32'hBAD0_BAD0;
    @(posedge clk);
    #1;
    head = 0; tail = 0; cnt = 0; m_rdata = '0;
    clr = 1'b0; push = 1'b0; pop = 1'b0;
    model_check(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    push = 1'b1; pop = 1'b1; wdata = 32'h1234_5678;
    repeat (2) @(posedge clk);
    #1;
    // R1 / R10: reset state, push and pop held high during clear
    model_check("R1");
    chk("R10", "empty after clear with push", 32'(empty), 32'd1);
    clr = 1'b0; push = 1'b0; pop = 1'b0;

    // Table walk: R2, R3, R7, R9 in a short pattern
    foreach (VEC[i]) begin
      step(VEC[i][68], VEC[i][67], VEC[i][66:35], "R3");
      chk("R3", "table rdata", rdata, VEC[i][34:3]);
      chk("R7", "table empty", 32'(empty), 32'(VEC[i][2]));
      chk("R8", "table fill_qtr", 32'(fill_qtr), 32'(VEC[i][1:0]));
    end

    // Fill to capacity, checking each quarter boundary (R8) and full (R5)
    do_clear(1'b0, 1'b0, "R1");
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 32'h1000_0000 + 32'(i), "R8");
    chk("R5", "full at 32", 32'(full), 32'd1);

    // Overflow attempt: ignored (R6)
    step(1'b1, 1'b0, 32'hDEAD_DEAD, "R6");
    step(1'b1, 1'b0, 32'hDEAD_BEEF, "R6");

    // Drain: order preserved, no stray word (R3, R6)
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 1'b1, 32'h0, "R3");
      chk("R6", "drained word", rdata, 32'h1000_0000 + 32'(i));
    end
    chk("R4", "empty after drain", 32'(empty), 32'd1);

    // Underflow: rdata holds (R7)
    step(1'b0, 1'b1, 32'h0, "R7");
    chk("R7", "rdata held on empty pop", rdata, 32'h1000_001F);

    // Simultaneous push and pop at a mid fill level (R9)
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 32'h2000_0000 + 32'(i), "R2");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 32'h3000_0000 + 32'(i), "R9");
      chk("R9", "fill_qtr steady", 32'(fill_qtr), 32'd1);
      chk("R9", "rdata oldest", rdata, 32'h2000_0000 + 32'(i));
    end

    // Clear with push and pop active: both have no effect (R10)
    do_clear(1'b1, 1'b1, "R10");
    step(1'b0, 1'b0, 32'h0, "R10");
    chk("R10", "still empty after clear", 32'(empty), 32'd1);

    // Refill shows only new words after clear (R1, R2)
    step(1'b1, 1'b0, 32'h4444_0000, "R2");
    step(1'b0, 1'b1, 32'h0, "R2");
    chk("R2", "first word after clear", rdata, 32'h4444_0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule